// File: doc/BRIEF.md
# Operand-2 Barrel Shifter with Carry

This purely combinational block prepares the second ALU operand. A data word passes through a left shift, a logical or arithmetic right shift, a rotate right, or a one-place extended rotate that moves the carry flag into the top bit. Alongside the shifted word it produces a shifter carry. The ALU can copy that carry into its C flag when a logical operation updates the flags.

The shift amount has five bits, so it ranges from 0 to 31. A count of zero leaves the word untouched and returns the incoming carry unchanged. For any other count, the carry is the last bit shifted out of the word. The extended rotate is selected by asserting a separate select line together with the rotate type. In that case the count is not used.

Top module: `oper2_shifter`

## Requirements
- R1: With a count of 0 and the extended rotate not selected, `result` equals `op_value` and `carry_out` equals `carry_in` for every shift type.
- R2: Type 00 (left shift) by n in 1..31 gives `op_value << n` with zeros in the low n bits, and `carry_out` = `op_value[32-n]`.
- R3: Type 01 (logical right) by n in 1..31 gives `op_value >> n` with zeros in the top n bits, and `carry_out` = `op_value[n-1]`.
- R4: Type 10 (arithmetic right) by n in 1..31 fills the top n bits with copies of `op_value[31]`, and `carry_out` = `op_value[n-1]`.
- R5: Type 11 (rotate right) by n in 1..31 moves the low n bits to the top, and `carry_out` = `op_value[n-1]`, which equals `result[31]`.
- R6: Type 11 with `rrx_sel` = 1 gives `{carry_in, op_value[31:1]}` and `carry_out` = `op_value[0]`, whatever the count.
- R7: `rrx_sel` has no effect for types 00, 01 and 10. Both outputs are the same as with `rrx_sel` = 0.
- R8: Outputs depend only on the present inputs. The same inputs give the same outputs regardless of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_value | input | 32 | Word to be shifted |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| shift_count | input | 5 | Shift distance, 0 to 31 |
| rrx_sel | input | 1 | With type 11, selects the one-place rotate through carry |
| carry_in | input | 1 | Present carry flag |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry for the ALU |

## Verification
The bound checker examines every input combination the bench applies. It checks that a zero count passes the word and carry through. It checks that the vacated bits hold zeros for both logical shifts and copies of the sign for the arithmetic shift. It checks that the rotate carry matches the new top bit, and that the extended rotate places the carry and bit 0 correctly.

The checker only checks the fill bits, the zero count, the rotate carry and the extended rotate. The bench's scenarios are needed for the rest:
- whether the surviving bits landed in the right positions;
- whether the left and right carries picked the right bit;
- that the select line is ignored for the other types;
- that a repeated input vector gives the same answer after different history.

The bench covers these by comparing each output against its own reference for every type and count.

// File: rtl/o2s_pkg.sv
package o2s_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_mode_e;

    typedef enum logic [1:0] {
        PATH_PASS   = 2'd0,
        PATH_LEFT   = 2'd1,
        PATH_RIGHT  = 2'd2,
        PATH_EXTEND = 2'd3
    } path_e;

    typedef struct packed {
        path_e      path;
        fill_mode_e fill;
    } shift_ctrl_t;

    // Chooses the datapath and the right-shift fill for one operation.
    function automatic shift_ctrl_t decode_ctrl(shift_kind_e kind, logic rrx, logic amt_zero);
        shift_ctrl_t c;
        c.path = PATH_PASS;
        c.fill = FILL_ZERO;
        if (kind == SH_ROR && rrx) begin
            c.path = PATH_EXTEND;
        end else if (amt_zero) begin
            c.path = PATH_PASS;
        end else begin
            unique case (kind)
                SH_LSL: c.path = PATH_LEFT;
                SH_LSR: begin c.path = PATH_RIGHT; c.fill = FILL_ZERO; end
                SH_ASR: begin c.path = PATH_RIGHT; c.fill = FILL_SIGN; end
                SH_ROR: begin c.path = PATH_RIGHT; c.fill = FILL_WRAP; end
                default: c.path = PATH_PASS;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/o2s_left_stages.sv
module o2s_left_stages #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] stage [AMT_W+1];

    assign stage[0] = data_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amount[k] ? {stage[k][WIDTH-1-STEP:0], {STEP{1'b0}}}
                                      : stage[k];
    end

    assign data_out = stage[AMT_W];
endmodule

// File: rtl/o2s_right_stages.sv
module o2s_right_stages
    import o2s_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    input  fill_mode_e       fill,
    output logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] stage [AMT_W+1];
    logic             fill_bit;
    logic             wrap;

    assign fill_bit = (fill == FILL_SIGN) && data_in[WIDTH-1];
    assign wrap     = (fill == FILL_WRAP);
    assign stage[0] = data_in;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [STEP-1:0] top_bits;
        assign top_bits   = wrap ? stage[k][STEP-1:0] : {STEP{fill_bit}};
        assign stage[k+1] = amount[k] ? {top_bits, stage[k][WIDTH-1:STEP]}
                                      : stage[k];
    end

    assign data_out = stage[AMT_W];
endmodule

// File: rtl/o2s_carry_pick.sv
module o2s_carry_pick #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    input  logic             is_left,
    output logic             carry_bit
);
    logic [AMT_W-1:0] idx;

    // Left: WIDTH-n wraps to the AMT_W-bit value of -n. Right: n-1.
    assign idx       = is_left ? (AMT_W'(0) - amount) : (amount - AMT_W'(1));
    assign carry_bit = data_in[idx];
endmodule

// File: rtl/oper2_shifter.sv
module oper2_shifter
    import o2s_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_value,
    input  logic [1:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_count,
    input  logic             rrx_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    shift_ctrl_t      ctrl;
    logic [WIDTH-1:0] left_val;
    logic [WIDTH-1:0] right_val;
    logic             picked_carry;

    assign ctrl = decode_ctrl(shift_kind_e'(shift_kind), rrx_sel, shift_count == '0);

    o2s_left_stages #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_left (
        .data_in  (op_value),
        .amount   (shift_count),
        .data_out (left_val)
    );

    o2s_right_stages #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_right (
        .data_in  (op_value),
        .amount   (shift_count),
        .fill     (ctrl.fill),
        .data_out (right_val)
    );

    o2s_carry_pick #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_carry (
        .data_in   (op_value),
        .amount    (shift_count),
        .is_left   (ctrl.path == PATH_LEFT),
        .carry_bit (picked_carry)
    );

    always_comb begin
        unique case (ctrl.path)
            PATH_LEFT: begin
                result    = left_val;
                carry_out = picked_carry;
            end
            PATH_RIGHT: begin
                result    = right_val;
                carry_out = picked_carry;
            end
            PATH_EXTEND: begin
                result    = {carry_in, op_value[WIDTH-1:1]};
                carry_out = op_value[0];
            end
            default: begin
                result    = op_value;
                carry_out = carry_in;
            end
        endcase
    end
endmodule

// File: rtl/oper2_shifter_chk.sv
module oper2_shifter_chk #(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] op_value,
    input logic [1:0]       shift_kind,
    input logic [AMT_W-1:0] shift_count,
    input logic             rrx_sel,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic [WIDTH-1:0] ones;
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;
    logic             ext;

    assign ones      = '1;
    assign low_mask  = (WIDTH'(1) << shift_count) - WIDTH'(1);
    assign high_mask = ~(ones >> shift_count);
    assign ext       = (shift_kind == 2'b11) && rrx_sel;

    always_comb begin
        if (!ext && shift_count == '0)
            a_r1_zero_pass: assert (result == op_value && carry_out == carry_in);
        if (shift_kind == 2'b00 && shift_count != '0)
            a_r2_left_low_zero: assert ((result & low_mask) == '0);
        if (shift_kind == 2'b01 && shift_count != '0)
            a_r3_lsr_high_zero: assert ((result & high_mask) == '0);
        if (shift_kind == 2'b10 && shift_count != '0)
            a_r4_asr_sign_fill: assert ((result & high_mask) ==
                                        (op_value[WIDTH-1] ? high_mask : '0));
        if (!ext && shift_kind == 2'b11 && shift_count != '0)
            a_r5_ror_carry_top: assert (carry_out == result[WIDTH-1]);
        if (ext)
            a_r6_rrx_ends: assert (result[WIDTH-1] == carry_in && carry_out == op_value[0]);
    end
endmodule

bind oper2_shifter oper2_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .op_value    (op_value),
    .shift_kind  (shift_kind),
    .shift_count (shift_count),
    .rrx_sel     (rrx_sel),
    .carry_in    (carry_in),
    .result      (result),
    .carry_out   (carry_out)
);

// File: tb/oper2_shifter_test.sv
`timescale 1ns/1ps
module oper2_shifter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_value = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_count = '0;
    logic        rrx_sel = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    oper2_shifter uut (
        .op_value    (op_value),
        .shift_kind  (shift_kind),
        .shift_count (shift_count),
        .rrx_sel     (rrx_sel),
        .carry_in    (carry_in),
        .result      (result),
        .carry_out   (carry_out)
    );

    function automatic void model(input logic [31:0] v, input logic [1:0] k, input int n,
                                  input logic r, input logic c,
                                  output logic [31:0] o, output logic co);
        if (k == 2'b11 && r) begin
            o = {c, v[31:1]}; co = v[0];
        end else if (n == 0) begin
            o = v; co = c;
        end else begin
            case (k)
                2'b00: begin o = v << n; co = v[32-n]; end
                2'b01: begin o = v >> n; co = v[n-1]; end
                2'b10: begin o = 32'($signed(v) >>> n); co = v[n-1]; end
                default: begin o = (v >> n) | (v << (32 - n)); co = v[n-1]; end
            endcase
        end
    endfunction

    task automatic apply(input logic [31:0] v, input logic [1:0] k, input int n,
                         input logic r, input logic c);
        @(negedge clk);
        op_value = v; shift_kind = k; shift_count = 5'(n); rrx_sel = r; carry_in = c;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [31:0] eo, input logic ec);
        checks++;
        if (result !== eo || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: kind=%b n=%0d rrx=%b cin=%b got %h/%b expected %h/%b",
                     req, shift_kind, shift_count, rrx_sel, carry_in, result, carry_out, eo, ec);
        end
    endtask

    task automatic run_model(input string req, input logic [31:0] v, input logic [1:0] k,
                             input int n, input logic r, input logic c);
        logic [31:0] eo; logic ec;
        apply(v, k, n, r, c);
        model(v, k, n, r, c, eo, ec);
        expect_out(req, eo, ec);
    endtask

    task automatic t_reset_and_zero();      // R1
        apply(32'hA5A5_0F0F, 2'b00, 0, 1'b0, 1'b1);
        expect_out("R1", 32'hA5A5_0F0F, 1'b1);
        for (int k = 0; k < 4; k++) begin
            apply(32'h8000_0001, 2'(k), 0, 1'b0, 1'b0);
            expect_out("R1", 32'h8000_0001, 1'b0);
        end
    endtask

    task automatic t_directed_corners();    // R2 R3 R4 R5
        apply(32'h8000_0001, 2'b00, 1, 1'b0, 1'b0);  expect_out("R2", 32'h0000_0002, 1'b1);
        apply(32'h0000_0001, 2'b00, 31, 1'b0, 1'b0); expect_out("R2", 32'h8000_0000, 1'b0);
        apply(32'h0000_0003, 2'b01, 1, 1'b0, 1'b0);  expect_out("R3", 32'h0000_0001, 1'b1);
        apply(32'h8000_0000, 2'b01, 31, 1'b0, 1'b1); expect_out("R3", 32'h0000_0001, 1'b0);
        apply(32'h8000_0000, 2'b10, 4, 1'b0, 1'b0);  expect_out("R4", 32'hF800_0000, 1'b0);
        apply(32'h8000_0000, 2'b10, 31, 1'b0, 1'b0); expect_out("R4", 32'hFFFF_FFFF, 1'b0);
        apply(32'h7FFF_FFFF, 2'b10, 8, 1'b0, 1'b0);  expect_out("R4", 32'h007F_FFFF, 1'b1);
        apply(32'h0000_0001, 2'b11, 1, 1'b0, 1'b0);  expect_out("R5", 32'h8000_0000, 1'b1);
        apply(32'h1234_5678, 2'b11, 16, 1'b0, 1'b0); expect_out("R5", 32'h5678_1234, 1'b0);
    endtask

    task automatic t_extended_rotate();     // R6
        apply(32'h0000_0003, 2'b11, 0, 1'b1, 1'b1);  expect_out("R6", 32'h8000_0001, 1'b1);
        apply(32'h0000_0002, 2'b11, 17, 1'b1, 1'b0); expect_out("R6", 32'h0000_0001, 1'b0);
        for (int n = 0; n < 32; n++) run_model("R6", $urandom, 2'b11, n, 1'b1, 1'($urandom));
    endtask

    task automatic t_select_ignored();      // R7
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 32; n += 5) begin
                logic [31:0] v; logic c; logic [31:0] eo; logic ec;
                v = $urandom; c = 1'($urandom);
                model(v, 2'(k), n, 1'b0, c, eo, ec);
                apply(v, 2'(k), n, 1'b1, c);
                expect_out("R7", eo, ec);
            end
    endtask

    task automatic t_sweep();               // R2 R3 R4 R5 against the reference
        string tag [4] = '{"R2", "R3", "R4", "R5"};
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 32; n++)
                for (int j = 0; j < 6; j++)
                    run_model(tag[k], $urandom, 2'(k), n, 1'b0, 1'($urandom));
    endtask

    task automatic t_history();             // R8
        logic [31:0] first_r; logic first_c;
        apply(32'hDEAD_BEEF, 2'b10, 7, 1'b0, 1'b1);
        first_r = result; first_c = carry_out;
        apply(32'h0123_4567, 2'b11, 3, 1'b1, 1'b0);
        apply(32'hFFFF_0000, 2'b00, 12, 1'b0, 1'b1);
        apply(32'hDEAD_BEEF, 2'b10, 7, 1'b0, 1'b1);
        expect_out("R8", first_r, first_c);
        run_model("R8", 32'hDEAD_BEEF, 2'b10, 7, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_and_zero();
        t_directed_corners();
        t_extended_rotate();
        t_select_ignored();
        t_sweep();
        t_history();
        done = 1'b1;
        finish_run();
    end
endmodule